// File: doc/BRIEF.md
# Pause Flow-Control Status Tracker

This block sits next to a MAC's pause flow-control logic and turns pause events into a maskable status word with an interrupt. A received pause frame comes in as a one-cycle strobe with its 16-bit quanta value. The transmitter reports whether it is paused through a level signal. The block records three sticky events: a pause frame arrived, the transmitter entered the paused state, and the transmitter left it. It also keeps the quanta of the latest pause frame in the upper half of the status word.

Software sees the status word, a writable mask and an interrupt line. A status read strobe clears the sticky events. The quanta field keeps its value until the next pause frame arrives. The interrupt is high while an unmasked event flag is set.

Top module: `pfc_status_tracker`

## Requirements
- R1: After reset, status_o is zero, mask_o is 0x00000007 (all three events masked) and irq_o is low.
- R2: A cycle with pause_rx_stb high sets status bit 0 and loads pause_rx_quanta into status bits 31:16. Both changes are visible after the next clock edge, and a quanta of zero is loaded like any other value.
- R3: A low-to-high change of tx_paused sets status bit 1. It is visible after the second clock edge following the change, and not after the first.
- R4: A high-to-low change of tx_paused sets status bit 2, with the same two-edge latency as R3.
- R5: A cycle with stat_rd high clears status bits 2:0 at the next edge. Status bits 31:16 keep their value.
- R6: When pause_rx_stb and stat_rd are high in the same cycle, bit 0 ends up set and bits 31:16 take the new quanta, while bits 1 and 2 are cleared.
- R7: irq_o is high in exactly those cycles where some status bit n in 2:0 is set and mask bit n is clear. It changes in the same cycle as the status and mask it depends on.
- R8: A cycle with mask_wr high loads mask_wdata into mask_o at the next edge. Mask bits 31:3 are stored and read back but have no effect on irq_o.
- R9: Status bits 15:3 always read as zero.
- R10: A tx_paused level that stays constant produces no further events once the flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pause_rx_stb | input | 1 | One-cycle strobe: pause frame received |
| pause_rx_quanta | input | 16 | Pause time carried by that frame |
| tx_paused | input | 1 | Level: transmitter currently paused |
| stat_rd | input | 1 | Status read strobe; clears the sticky events |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 32 | Mask write data (bits 2:0 gate events 2:0) |
| status_o | output | 32 | {quanta[15:0], 13'b0, left_pause, entered_pause, frame_rx} |
| mask_o | output | 32 | Current mask register |
| irq_o | output | 1 | Interrupt: any unmasked event flag set |

## Verification
The hardest case to reach from the ports is a read strobe that lands in the same cycle as a new pause frame, combined with a pending paused-state event. In that cycle the set and the clear act on the same flag register, and the quanta field is reloaded. The stimulus first raises and then lowers tx_paused so that the exit flag is pending. It then issues the read and a frame with a fresh quanta in one cycle, and expects bit 0 set, bit 2 cleared and the new quanta. A further point to reach is a mask whose upper bits are all ones while the low bits are zero; the stimulus writes that value while a flag is pending to show that the upper bits leave the interrupt alone.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int EV_N   = 3;
  localparam int EV_RX  = 0;
  localparam int EV_ON  = 1;
  localparam int EV_OFF = 2;
endpackage

// File: rtl/pfc_level_edge.sv
module pfc_level_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q, lvl_qq;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      lvl_qq <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      lvl_qq <= lvl_q;
    end
  end

  assign rise_o = lvl_q & ~lvl_qq;
  assign fall_o = ~lvl_q & lvl_qq;
endmodule

// File: rtl/pfc_event_flag.sv
module pfc_event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic nxt_o
);
  // a new event wins over a clearing read in the same cycle
  assign nxt_o = set_i | (flag_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= nxt_o;
  end
endmodule

// File: rtl/pfc_irq_gen.sv
module pfc_irq_gen #(
  parameter int MASK_W   = 32,
  parameter int EV_W     = 3,
  parameter logic [MASK_W-1:0] MASK_RST = MASK_W'(7)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [MASK_W-1:0] wdata_i,
  input  logic [EV_W-1:0]   flag_nxt_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              irq_o
);
  logic [MASK_W-1:0] mask_nxt;

  assign mask_nxt = wr_i ? wdata_i : mask_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= MASK_RST;
      irq_o  <= 1'b0;
    end else begin
      mask_o <= mask_nxt;
      irq_o  <= |(flag_nxt_i & ~mask_nxt[EV_W-1:0]);
    end
  end
endmodule

// File: rtl/pfc_status_tracker.sv
module pfc_status_tracker
  import pfc_pkg::*;
#(
  parameter int STAT_W   = 32,
  parameter int QUANTA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pause_rx_stb,
  input  logic [QUANTA_W-1:0] pause_rx_quanta,
  input  logic                tx_paused,
  input  logic                stat_rd,
  input  logic                mask_wr,
  input  logic [STAT_W-1:0]   mask_wdata,
  output logic [STAT_W-1:0]   status_o,
  output logic [STAT_W-1:0]   mask_o,
  output logic                irq_o
);
  localparam int RSV_W = STAT_W - QUANTA_W - EV_N;

  logic              ev_rise, ev_fall;
  logic [EV_N-1:0]   ev_set, ev_flag, ev_nxt;
  logic [QUANTA_W-1:0] quanta_q;

  pfc_level_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (tx_paused),
    .rise_o (ev_rise),
    .fall_o (ev_fall)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_RX]  = pause_rx_stb;
    ev_set[EV_ON]  = ev_rise;
    ev_set[EV_OFF] = ev_fall;
  end

  for (genvar g = 0; g < EV_N; g++) begin : g_flag
    pfc_event_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (ev_set[g]),
      .clr_i  (stat_rd),
      .flag_o (ev_flag[g]),
      .nxt_o  (ev_nxt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)               quanta_q <= '0;
    else if (pause_rx_stb) quanta_q <= pause_rx_quanta;
  end

  pfc_irq_gen #(
    .MASK_W   (STAT_W),
    .EV_W     (EV_N),
    .MASK_RST ({{(STAT_W-EV_N){1'b0}}, {EV_N{1'b1}}})
  ) u_irq (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (mask_wr),
    .wdata_i    (mask_wdata),
    .flag_nxt_i (ev_nxt),
    .mask_o     (mask_o),
    .irq_o      (irq_o)
  );

  assign status_o = {quanta_q, {RSV_W{1'b0}}, ev_flag};
endmodule

// File: rtl/pfc_status_tracker_chk.sv
module pfc_status_tracker_chk (
  input logic        clk,
  input logic        rst,
  input logic        pause_rx_stb,
  input logic [15:0] pause_rx_quanta,
  input logic        stat_rd,
  input logic        mask_wr,
  input logic [31:0] mask_wdata,
  input logic [31:0] status_o,
  input logic [31:0] mask_o,
  input logic        irq_o
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_o[15:3] == 13'd0); // R9

  AST_RX_LOAD: assert property (@(posedge clk) disable iff (rst)
    pause_rx_stb |=> status_o[0] && status_o[31:16] == $past(pause_rx_quanta)); // R2

  AST_RD_CLR: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !pause_rx_stb) |=> !status_o[0]); // R5

  AST_QUANTA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pause_rx_stb |=> $stable(status_o[31:16])); // R5

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status_o[2:0] & ~mask_o[2:0])); // R7

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> mask_o == $past(mask_wdata)); // R8
endmodule

bind pfc_status_tracker pfc_status_tracker_chk i_chk (
  .clk             (clk),
  .rst             (rst),
  .pause_rx_stb    (pause_rx_stb),
  .pause_rx_quanta (pause_rx_quanta),
  .stat_rd         (stat_rd),
  .mask_wr         (mask_wr),
  .mask_wdata      (mask_wdata),
  .status_o        (status_o),
  .mask_o          (mask_o),
  .irq_o           (irq_o)
);

// File: tb/test_pfc_status_tracker.sv
`timescale 1ns/1ps
module test_pfc_status_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pause_rx_stb = 1'b0;
  logic [15:0] pause_rx_quanta = '0;
  logic        tx_paused = 1'b0;
  logic        stat_rd = 1'b0;
  logic        mask_wr = 1'b0;
  logic [31:0] mask_wdata = '0;
  logic [31:0] status_o, mask_o;
  logic        irq_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  int          q_due[$];
  logic [31:0] q_st[$], q_mk[$];
  logic        q_irq[$];
  string       q_tag[$];

  logic [31:0] e_st, e_mk;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pfc_status_tracker i_pfc_status_tracker (
    .clk(clk), .rst(rst), .pause_rx_stb(pause_rx_stb),
    .pause_rx_quanta(pause_rx_quanta), .tx_paused(tx_paused),
    .stat_rd(stat_rd), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o));

  function automatic logic exp_irq(logic [31:0] st, logic [31:0] mk);
    return |(st[2:0] & ~mk[2:0]);
  endfunction

  // driver side: queue the expected outputs for a given future cycle
  task automatic push(int ahead, string tag);
    q_due.push_back(cyc + ahead);
    q_st.push_back(e_st);
    q_mk.push_back(e_mk);
    q_irq.push_back(exp_irq(e_st, e_mk));
    q_tag.push_back(tag);
  endtask

  task automatic tick();
    @(negedge clk);
    pause_rx_stb = 1'b0; stat_rd = 1'b0; mask_wr = 1'b0;
  endtask

  // monitor: compare when an item falls due
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      logic [31:0] st, mk; logic iq; string tg;
      st = q_st.pop_front(); mk = q_mk.pop_front();
      iq = q_irq.pop_front(); tg = q_tag.pop_front();
      void'(q_due.pop_front());
      n_cmp++;
      if (status_o !== st || mask_o !== mk || irq_o !== iq) begin
        n_bad++;
        $display("FAIL %s: status=%h mask=%h irq=%b expected status=%h mask=%h irq=%b",
                 tg, status_o, mask_o, irq_o, st, mk, iq);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    e_st = 32'h0; e_mk = 32'h7;
    push(1, "R1 reset state");
    tick();

    // R2: frame with all events masked, irq stays low (R7)
    pause_rx_stb = 1'b1; pause_rx_quanta = 16'h1234;
    e_st = 32'h1234_0001;
    push(1, "R2/R9 frame latch, masked");
    tick();

    // R8/R7: unmask with upper mask bits set
    mask_wr = 1'b1; mask_wdata = 32'hFFFF_FFF8;
    e_mk = 32'hFFFF_FFF8;
    push(1, "R8 upper mask bits no effect, R7 irq");
    tick();

    // R5: read clears, quanta held
    stat_rd = 1'b1;
    e_st = 32'h1234_0000;
    push(1, "R5 read clear");
    tick();

    // R3: enter paused state
    tx_paused = 1'b1;
    push(1, "R3 not yet after one edge");
    e_st = 32'h1234_0002;
    push(2, "R3 entry flag");
    tick(); tick();

    stat_rd = 1'b1;
    e_st = 32'h1234_0000;
    push(1, "R5 read clear entry flag");
    tick();
    // R10: level held, nothing new
    push(5, "R10 steady level");
    repeat (5) tick();

    // R4: leave paused state
    tx_paused = 1'b0;
    push(1, "R4 not yet after one edge");
    e_st = 32'h1234_0004;
    push(2, "R4 exit flag");
    tick(); tick();

    // R6: read and new frame in the same cycle
    stat_rd = 1'b1; pause_rx_stb = 1'b1; pause_rx_quanta = 16'hBEEF;
    e_st = 32'hBEEF_0001;
    push(1, "R6 read with frame");
    tick();

    // R8: mask bit 0 -> irq drops (R7)
    mask_wr = 1'b1; mask_wdata = 32'h0000_0001;
    e_mk = 32'h0000_0001;
    push(1, "R8 mask frame event, R7 irq low");
    tick();

    stat_rd = 1'b1;
    e_st = 32'hBEEF_0000;
    push(1, "R5 quanta kept after read");
    tick();

    // R2: zero quanta loads
    pause_rx_stb = 1'b1; pause_rx_quanta = 16'h0000;
    e_st = 32'h0000_0001;
    push(1, "R2 zero quanta");
    tick();

    repeat (3) tick();
    if (q_due.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", q_due.size());
    end
    finish_run();
  end
endmodule